// File: doc/BRIEF.md
# DMA Channel Interrupt Status and Clear Registers

This block is the register-side interrupt logic of a multi-channel DMA controller; the channel count is a parameter from 2 to 8. The transfer engines pulse one terminal-count input and one error input per channel. The block turns each pulse into a sticky raw flag, and software clears the flags by writing ones. The transfer datapath, arbitration and peripheral request handling belong to other blocks.

Each channel has a 32-bit configuration word in the per-channel window. The block reads three bits of that word. Bit 0 marks the channel as enabled. Bit 14 unmasks the channel's error flag and bit 15 unmasks its terminal-count flag. Software reads the flags through a 32-bit register port as raw, masked or combined status, and also reads a bitmap of the enabled channels. A single level interrupt output follows the masked flags.

Register accesses take one clock cycle. Read data and the error strobe appear in the cycle after the access. Read data then holds until the next read.

Top module: `dma_irq_regs`

## Requirements
- R1: After reset every raw flag and every configuration word is zero, `irq` is low, `acc_err` is low and `acc_rdata` is zero.
- R2: A one on `tc_set[c]` or `err_set[c]` sets that channel's raw flag at the next edge. Raw terminal-count flags read at byte 0x014 and raw error flags read at byte 0x018, with bit c for channel c, whatever the masks hold.
- R3: The masked terminal-count status at byte 0x004 is the raw terminal-count flags ANDed with bit 15 of each channel's configuration word. The masked error status at byte 0x00C is the raw error flags ANDed with bit 14.
- R4: A read of byte 0x000 returns the OR of the masked terminal-count status and the masked error status.
- R5: A write to byte 0x008 clears each terminal-count flag whose bit is 1 in the write data, and a write to byte 0x010 clears error flags the same way. Flags whose bits are 0 are kept.
- R6: When a set pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R7: A read of byte 0x01C returns a bitmap with bit c set exactly when bit 0 of channel c's configuration word is 1.
- R8: `irq` is high in every cycle in which any masked terminal-count or masked error flag is set, and low otherwise.
- R9: Channel c's configuration word is read and written at byte 0x100 + 32*c + 0x10. A channel number at or above the channel count is an error: a read returns zero, and a write changes nothing.
- R10: Every other access is an error. This covers reads of the two clear words, writes to the status words, other per-channel offsets, global words above 7, and addresses at 0x200 or above. Such a read returns zero and a write has no effect. Each error raises `acc_err` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access in this cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, registered, held until the next read |
| acc_err | output | 1 | One-cycle strobe for an access to an unimplemented location |
| tc_set | input | NUM_CH | Per-channel terminal-count set pulses |
| err_set | input | NUM_CH | Per-channel error set pulses |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with six channels. That count is not a power of two, so the channel-6 and channel-7 slots still decode inside the per-channel window but lie beyond the count. Writes and reads there can therefore be checked for the error strobe and for leaving the enabled bitmap and other state untouched. With six channels the upper bits of a clearing write of all ones fall outside the flag vector, and the mask bits of channels that hold pending flags can be turned on and off to move `irq` in both directions.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  localparam int MAX_CH       = 8;
  localparam int WORD_W       = 32;
  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_ERRM_BIT = 14;
  localparam int CFG_TCM_BIT  = 15;
  localparam logic [2:0] CH_CFG_SLOT = 3'd4;

  typedef enum logic [3:0] {
    KIND_NONE,
    KIND_COMBINED,
    KIND_TC_MASKED,
    KIND_TC_CLEAR,
    KIND_ERR_MASKED,
    KIND_ERR_CLEAR,
    KIND_TC_RAW,
    KIND_ERR_RAW,
    KIND_ENABLED,
    KIND_CH_CFG
  } reg_kind_e;

  // sticky flag update: a set pulse beats a clear in the same cycle
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return (cur & ~clr) | set;
  endfunction

  // a flag is visible to the interrupt only when its mask bit is set
  function automatic logic flag_visible(input logic raw, input logic mask);
    return raw & mask;
  endfunction

endpackage

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output reg_kind_e         kind,
  output logic [2:0]        ch,
  output logic              bad
);
  localparam int HI_W = ADDR_W - 8;

  logic [HI_W-1:0] region;
  logic [5:0]      gword;
  logic [2:0]      cslot;
  logic [1:0]      unused_lo;

  assign region    = addr[ADDR_W-1:8];
  assign gword     = addr[7:2];
  assign ch        = addr[7:5];
  assign cslot     = addr[4:2];
  assign unused_lo = addr[1:0];

  always_comb begin
    kind = KIND_NONE;
    if (region == HI_W'(0)) begin
      case (gword)
        6'd0:    kind = wr ? KIND_NONE     : KIND_COMBINED;
        6'd1:    kind = wr ? KIND_NONE     : KIND_TC_MASKED;
        6'd2:    kind = wr ? KIND_TC_CLEAR : KIND_NONE;
        6'd3:    kind = wr ? KIND_NONE     : KIND_ERR_MASKED;
        6'd4:    kind = wr ? KIND_ERR_CLEAR : KIND_NONE;
        6'd5:    kind = wr ? KIND_NONE     : KIND_TC_RAW;
        6'd6:    kind = wr ? KIND_NONE     : KIND_ERR_RAW;
        6'd7:    kind = wr ? KIND_NONE     : KIND_ENABLED;
        default: kind = KIND_NONE;
      endcase
    end else if (region == HI_W'(1)) begin
      if (cslot == CH_CFG_SLOT && int'(ch) < NUM_CH) kind = KIND_CH_CFG;
    end
  end

  assign bad = (kind == KIND_NONE);

endmodule

// File: rtl/dma_irq_flagbank.sv
module dma_irq_flagbank
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  input  logic [NUM_CH-1:0] mask_i,
  output logic [NUM_CH-1:0] raw_o,
  output logic [NUM_CH-1:0] masked_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_flag
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= flag_next(bit_q, set_i[c], clr_i[c]);
    end
    assign raw_o[c]    = bit_q;
    assign masked_o[c] = flag_visible(bit_q, mask_i[c]);
  end

endmodule

// File: rtl/dma_irq_cfgbank.sv
module dma_irq_cfgbank
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_ch,
  input  logic [WORD_W-1:0] wdata,
  input  logic [2:0]        rd_ch,
  output logic [WORD_W-1:0] rd_data,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] tc_mask_o,
  output logic [NUM_CH-1:0] err_mask_o
);
  logic [WORD_W-1:0] cfg_arr [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         word_q <= '0;
      else if (wr_en && wr_ch == 3'(c))   word_q <= wdata;
    end
    assign cfg_arr[c]    = word_q;
    assign en_o[c]       = word_q[CFG_EN_BIT];
    assign tc_mask_o[c]  = word_q[CFG_TCM_BIT];
    assign err_mask_o[c] = word_q[CFG_ERRM_BIT];
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_ch == 3'(c)) rd_data = cfg_arr[c];
    end
  end

endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  output logic              acc_err,
  input  logic [NUM_CH-1:0] tc_set,
  input  logic [NUM_CH-1:0] err_set,
  output logic              irq
);
  localparam int PAD_W = WORD_W - NUM_CH;

  reg_kind_e         kind;
  logic [2:0]        ch_idx;
  logic              acc_bad;
  logic              acc_ok_wr;
  logic              acc_rd;
  logic [NUM_CH-1:0] tc_clr, err_clr;
  logic [NUM_CH-1:0] tc_raw, err_raw, tc_masked, err_masked;
  logic [NUM_CH-1:0] ch_en, tc_mask, err_mask;
  logic [WORD_W-1:0] cfg_rd;
  logic [WORD_W-1:0] rd_mux;
  logic [WORD_W-1:0] rdata_q;
  logic              err_q;

  dma_irq_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
    .addr (acc_addr),
    .wr   (acc_write),
    .kind (kind),
    .ch   (ch_idx),
    .bad  (acc_bad)
  );

  assign acc_ok_wr = acc_valid && acc_write && !acc_bad;
  assign acc_rd    = acc_valid && !acc_write;
  assign tc_clr    = (acc_ok_wr && kind == KIND_TC_CLEAR)  ? acc_wdata[NUM_CH-1:0] : '0;
  assign err_clr   = (acc_ok_wr && kind == KIND_ERR_CLEAR) ? acc_wdata[NUM_CH-1:0] : '0;

  dma_irq_cfgbank #(.NUM_CH(NUM_CH)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (acc_ok_wr && kind == KIND_CH_CFG),
    .wr_ch      (ch_idx),
    .wdata      (acc_wdata),
    .rd_ch      (ch_idx),
    .rd_data    (cfg_rd),
    .en_o       (ch_en),
    .tc_mask_o  (tc_mask),
    .err_mask_o (err_mask)
  );

  dma_irq_flagbank #(.NUM_CH(NUM_CH)) u_tc_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (tc_set),
    .clr_i    (tc_clr),
    .mask_i   (tc_mask),
    .raw_o    (tc_raw),
    .masked_o (tc_masked)
  );

  dma_irq_flagbank #(.NUM_CH(NUM_CH)) u_err_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (err_set),
    .clr_i    (err_clr),
    .mask_i   (err_mask),
    .raw_o    (err_raw),
    .masked_o (err_masked)
  );

  always_comb begin
    case (kind)
      KIND_COMBINED:   rd_mux = {{PAD_W{1'b0}}, tc_masked | err_masked};
      KIND_TC_MASKED:  rd_mux = {{PAD_W{1'b0}}, tc_masked};
      KIND_ERR_MASKED: rd_mux = {{PAD_W{1'b0}}, err_masked};
      KIND_TC_RAW:     rd_mux = {{PAD_W{1'b0}}, tc_raw};
      KIND_ERR_RAW:    rd_mux = {{PAD_W{1'b0}}, err_raw};
      KIND_ENABLED:    rd_mux = {{PAD_W{1'b0}}, ch_en};
      KIND_CH_CFG:     rd_mux = cfg_rd;
      default:         rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= acc_valid && acc_bad;
      if (acc_rd) rdata_q <= acc_bad ? '0 : rd_mux;
    end
  end

  assign acc_rdata = rdata_q;
  assign acc_err   = err_q;
  assign irq       = |(tc_masked | err_masked);

endmodule

// File: rtl/dma_irq_regs_chk.sv
module dma_irq_regs_chk #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [31:0]       acc_rdata,
  input logic              acc_err,
  input logic [NUM_CH-1:0] tc_set,
  input logic [NUM_CH-1:0] err_set,
  input logic [NUM_CH-1:0] tc_raw,
  input logic [NUM_CH-1:0] err_raw,
  input logic              irq
);
  // R2
  tc_set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_set) |=> ((tc_raw & $past(tc_set)) == $past(tc_set)));

  // R6
  err_set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_set) |=> ((err_raw & $past(err_set)) == $past(err_set)));

  // R5
  tc_drop_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~tc_raw & $past(tc_raw)) != '0) |->
      $past(acc_valid && acc_write && acc_addr == ADDR_W'(12'h008)));

  // R5
  err_drop_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~err_raw & $past(err_raw)) != '0) |->
      $past(acc_valid && acc_write && acc_addr == ADDR_W'(12'h010)));

  // R8
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((|tc_set) || (|err_set) || (acc_valid && acc_write)));

  // R10
  err_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(acc_valid));

  // R10
  err_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_err && !$past(acc_write)) |-> (acc_rdata == '0));

endmodule

bind dma_irq_regs dma_irq_regs_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .acc_addr  (acc_addr),
  .acc_rdata (acc_rdata),
  .acc_err   (acc_err),
  .tc_set    (tc_set),
  .err_set   (err_set),
  .tc_raw    (tc_raw),
  .err_raw   (err_raw),
  .irq       (irq)
);

// File: tb/dma_irq_regs_bench.sv
module dma_irq_regs_bench;
  localparam int NCH = 6;
  localparam int AW  = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic          acc_write = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [31:0]   acc_wdata = '0;
  logic [31:0]   acc_rdata;
  logic          acc_err;
  logic [NCH-1:0] tc_set = '0;
  logic [NCH-1:0] err_set = '0;
  logic          irq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dma_irq_regs #(.NUM_CH(NCH), .ADDR_W(AW)) u_dma_irq_regs (
    .clk (clk), .rst_n (rst_n), .acc_valid (acc_valid), .acc_write (acc_write),
    .acc_addr (acc_addr), .acc_wdata (acc_wdata), .acc_rdata (acc_rdata),
    .acc_err (acc_err), .tc_set (tc_set), .err_set (err_set), .irq (irq)
  );

  typedef struct packed {
    logic        sel;
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [7:0]  tcs;
    logic [7:0]  ers;
    logic        chk;
    logic [31:0] exp_rd;
    logic        exp_err;
    logic        exp_irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  // Fields: sel wr addr wdata tc_set err_set check_rdata exp_rdata exp_err exp_irq req
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,12'h110,32'h0000_8001,8'h00,8'h00,1'b0,32'h0,1'b0,1'b0,4'd9},  // R9 ch0 cfg
    '{1'b1,1'b1,12'h130,32'h0000_4001,8'h00,8'h00,1'b0,32'h0,1'b0,1'b0,4'd9},  // R9 ch1 cfg
    '{1'b1,1'b1,12'h1B0,32'h0000_C000,8'h00,8'h00,1'b0,32'h0,1'b0,1'b0,4'd9},  // R9 ch5 cfg
    '{1'b1,1'b0,12'h01C,32'h0,8'h00,8'h00,1'b1,32'h3,1'b0,1'b0,4'd7},          // R7
    '{1'b0,1'b0,12'h000,32'h0,8'h03,8'h00,1'b0,32'h0,1'b0,1'b1,4'd2},          // R2 set tc
    '{1'b1,1'b0,12'h014,32'h0,8'h00,8'h00,1'b1,32'h3,1'b0,1'b1,4'd2},
    '{1'b1,1'b0,12'h004,32'h0,8'h00,8'h00,1'b1,32'h1,1'b0,1'b1,4'd3},          // R3
    '{1'b0,1'b0,12'h000,32'h0,8'h00,8'h21,1'b0,32'h0,1'b0,1'b1,4'd2},
    '{1'b1,1'b0,12'h018,32'h0,8'h00,8'h00,1'b1,32'h21,1'b0,1'b1,4'd2},
    '{1'b1,1'b0,12'h00C,32'h0,8'h00,8'h00,1'b1,32'h20,1'b0,1'b1,4'd3},
    '{1'b1,1'b0,12'h000,32'h0,8'h00,8'h00,1'b1,32'h21,1'b0,1'b1,4'd4},         // R4
    '{1'b1,1'b1,12'h008,32'h1,8'h00,8'h00,1'b0,32'h0,1'b0,1'b1,4'd5},          // R5
    '{1'b1,1'b0,12'h014,32'h0,8'h00,8'h00,1'b1,32'h2,1'b0,1'b1,4'd5},
    '{1'b1,1'b1,12'h010,32'h20,8'h00,8'h00,1'b0,32'h0,1'b0,1'b0,4'd8},         // R8 irq drops
    '{1'b1,1'b0,12'h000,32'h0,8'h00,8'h00,1'b1,32'h0,1'b0,1'b0,4'd4},
    '{1'b1,1'b1,12'h008,32'h2,8'h02,8'h00,1'b0,32'h0,1'b0,1'b0,4'd6},          // R6
    '{1'b1,1'b0,12'h014,32'h0,8'h00,8'h00,1'b1,32'h2,1'b0,1'b0,4'd6},
    '{1'b1,1'b1,12'h130,32'h0000_C001,8'h00,8'h00,1'b0,32'h0,1'b0,1'b1,4'd8},  // R8 irq rises
    '{1'b1,1'b0,12'h130,32'h0,8'h00,8'h00,1'b1,32'h0000_C001,1'b0,1'b1,4'd9},
    '{1'b1,1'b1,12'h1D0,32'hFFFF_FFFF,8'h00,8'h00,1'b0,32'h0,1'b1,1'b1,4'd9},  // R9 ch6 absent
    '{1'b1,1'b0,12'h1D0,32'h0,8'h00,8'h00,1'b1,32'h0,1'b1,1'b1,4'd9},
    '{1'b1,1'b0,12'h01C,32'h0,8'h00,8'h00,1'b1,32'h3,1'b0,1'b1,4'd9},
    '{1'b1,1'b0,12'h008,32'h0,8'h00,8'h00,1'b1,32'h0,1'b1,1'b1,4'd10},         // R10
    '{1'b1,1'b1,12'h014,32'h0,8'h00,8'h00,1'b0,32'h0,1'b1,1'b1,4'd10},
    '{1'b1,1'b0,12'h014,32'h0,8'h00,8'h00,1'b1,32'h2,1'b0,1'b1,4'd10},
    '{1'b1,1'b0,12'h104,32'h0,8'h00,8'h00,1'b1,32'h0,1'b1,1'b1,4'd10},
    '{1'b1,1'b0,12'h200,32'h0,8'h00,8'h00,1'b1,32'h0,1'b1,1'b1,4'd10},
    '{1'b1,1'b0,12'h040,32'h0,8'h00,8'h00,1'b1,32'h0,1'b1,1'b1,4'd10},
    '{1'b1,1'b1,12'h010,32'hFFFF_FFFF,8'h00,8'h02,1'b0,32'h0,1'b0,1'b1,4'd6},  // R6 err side
    '{1'b1,1'b0,12'h018,32'h0,8'h00,8'h00,1'b1,32'h2,1'b0,1'b1,4'd6},
    '{1'b0,1'b0,12'h000,32'h0,8'h00,8'h00,1'b1,32'h2,1'b0,1'b1,4'd10}          // R10 strobe ends
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic drive_idle();
    acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0; acc_wdata = '0;
    tc_set = '0; err_set = '0;
  endtask

  task automatic do_read(input logic [11:0] a, input string tag, input logic [31:0] exp);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
    @(negedge clk);
    drive_idle();
    check(tag, acc_rdata, exp);
  endtask

  initial begin
    drive_idle();
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 err", {31'b0, acc_err}, 32'h0);
    check("R1 rdata", acc_rdata, 32'h0);
    rst_n = 1'b1;
    do_read(12'h000, "R1 combined", 32'h0);
    do_read(12'h014, "R1 raw tc", 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i > 0) begin
        if (VECS[i-1].chk)
          check($sformatf("R%0d rdata v%0d", VECS[i-1].req, i-1), acc_rdata, VECS[i-1].exp_rd);
        check($sformatf("R%0d err v%0d", VECS[i-1].req, i-1), {31'b0, acc_err}, {31'b0, VECS[i-1].exp_err});
        check($sformatf("R%0d irq v%0d", VECS[i-1].req, i-1), {31'b0, irq}, {31'b0, VECS[i-1].exp_irq});
      end
      acc_valid = VECS[i].sel;
      acc_write = VECS[i].wr;
      acc_addr  = VECS[i].addr;
      acc_wdata = VECS[i].wdata;
      tc_set    = VECS[i].tcs[NCH-1:0];
      err_set   = VECS[i].ers[NCH-1:0];
    end
    @(negedge clk);
    drive_idle();
    if (VECS[NV-1].chk)
      check($sformatf("R%0d rdata last", VECS[NV-1].req), acc_rdata, VECS[NV-1].exp_rd);
    check("R10 err last", {31'b0, acc_err}, {31'b0, VECS[NV-1].exp_err});
    check("R8 irq last", {31'b0, irq}, {31'b0, VECS[NV-1].exp_irq});

    // R1 reset in the middle of activity clears flags, config and irq
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    do_read(12'h014, "R1 raw tc after reset", 32'h0);
    do_read(12'h018, "R1 raw err after reset", 32'h0);
    do_read(12'h110, "R1 cfg0 after reset", 32'h0);
    do_read(12'h01C, "R7 enabled after reset", 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule